// File: doc/BRIEF.md
# Multi-Precision Signaling Floating-Point Comparator

This block compares two floating-point values held in raw 64-bit operand words and reports the outcome as a four-bit N/Z/C/V condition code. A two-bit type code picks the precision: half, single or double. The active value sits in the low bits of each word, and any bits above the selected width are ignored. A zero-select bit replaces the second operand with positive zero of the selected width. In that case the second operand word has no effect.

The compare is signaling. A NaN on either side, quiet or signaling, gives the unordered code and raises an invalid-operation event. Depending on a trap-enable bit, that event either sets a sticky status bit, which stays set until a clear input is pulsed, or produces a one-cycle trap-request pulse. The reserved type code, and the half-precision code while the half-precision enable is low, are treated as undefined encodings. They report undefined, leave the condition code untouched and raise no exception.

Each request is a one-cycle valid strobe. The results are registered and appear one clock later together with a valid-out pulse. Non-NaN values are ordered through a monotonic integer key built from each sign-magnitude encoding. Signed zeros are folded together before the key is formed, and subnormals are compared exactly.

Top module: `fp_sigcmp`

## Requirements
- R1: Type code 2'b00 compares the low 32 bits as single precision, 2'b01 the full 64 bits as double precision, and 2'b11 the low 16 bits as half precision. Operand bits above the selected width have no effect on the result.
- R2: Type code 2'b10 is reserved. It sets `undef` with `out_valid`, leaves `flags` at its previous value, and changes neither `inv_sticky` nor `trap_pulse`, even when the operands hold NaNs.
- R3: Type code 2'b11 while `half_en` is low behaves as an undefined encoding, exactly as in R2.
- R4: When `zero_sel` is high, the second operand is positive zero of the selected width and `opb` has no effect, including when `opb` holds a NaN.
- R5: A legal compare writes `flags` as {N,Z,C,V}: 4'b1000 when the first operand is less, 4'b0110 when the operands are equal, 4'b0010 when the first operand is greater, and 4'b0011 when unordered.
- R6: Any NaN operand, quiet or signaling, in a legal compare gives 4'b0011 and raises the invalid-operation event.
- R7: Positive and negative zero compare equal. Subnormals are ordered exactly by value, with no flushing. Infinities order beyond every finite value.
- R8: With `trap_en` low, an invalid event sets `inv_sticky`. The bit holds until `clr_inv` is high at a clock edge. When a new invalid event arrives in the same cycle as the clear, the set wins.
- R9: With `trap_en` high, an invalid event asserts `trap_pulse` for exactly the one result cycle and does not set `inv_sticky`.
- R10: `out_valid` is high exactly in the cycle after `in_valid` is sampled high. After reset, `out_valid`, `flags`, `undef`, `inv_sticky` and `trap_pulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; all request inputs are sampled when it is high |
| fmt | input | 2 | Type code: 00 single, 01 double, 11 half, 10 reserved |
| zero_sel | input | 1 | Mode bit: compare the first operand against positive zero |
| half_en | input | 1 | Half-precision feature enable |
| trap_en | input | 1 | Invalid event requests a trap instead of setting the sticky bit |
| clr_inv | input | 1 | Clears the sticky invalid bit |
| opa | input | 64 | First operand word, right-aligned |
| opb | input | 64 | Second operand word, right-aligned |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| flags | output | 4 | Condition code {N,Z,C,V} |
| undef | output | 1 | The request carried an undefined encoding |
| inv_sticky | output | 1 | Sticky invalid-operation status |
| trap_pulse | output | 1 | One-cycle trap request for an invalid operation |

## Verification
The bench builds the block with its default field widths: 5/10, 8/23 and 11/52 exponent/mantissa bits. With these widths all three lanes take real IEEE encodings, so the stimulus can use the actual patterns for these cases:
- quiet and signaling NaNs
- infinities
- the largest finite values
- single-ulp subnormals

Under the same build, each lane's upper-bit masking is tested by filling the ignored bits with patterns that would decode as NaNs in a wider format.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam logic [1:0] FMT_SINGLE = 2'b00;
    localparam logic [1:0] FMT_DOUBLE = 2'b01;
    localparam logic [1:0] FMT_RSVD   = 2'b10;
    localparam logic [1:0] FMT_HALF   = 2'b11;

    // lane indices
    localparam int LN_HALF   = 0;
    localparam int LN_SINGLE = 1;
    localparam int LN_DOUBLE = 2;
    localparam int NUM_LANES = 3;

    // condition codes {N,Z,C,V}
    localparam logic [3:0] CC_LT    = 4'b1000;
    localparam logic [3:0] CC_EQ    = 4'b0110;
    localparam logic [3:0] CC_GT    = 4'b0010;
    localparam logic [3:0] CC_UNORD = 4'b0011;

    typedef struct packed {
        logic       vld;
        logic [3:0] cc;
        logic       undef;
        logic       sticky;
        logic       trap;
    } cmp_state_t;

endpackage

// File: rtl/fpcmp_decode.sv
module fpcmp_decode
    import fpcmp_pkg::*;
(
    input  logic [1:0]           fmt_i,
    input  logic                 half_en_i,
    output logic                 legal_o,
    output logic [NUM_LANES-1:0] sel_o
);

    always_comb begin
        sel_o   = '0;
        legal_o = 1'b0;
        unique case (fmt_i)
            FMT_SINGLE: begin
                sel_o[LN_SINGLE] = 1'b1;
                legal_o          = 1'b1;
            end
            FMT_DOUBLE: begin
                sel_o[LN_DOUBLE] = 1'b1;
                legal_o          = 1'b1;
            end
            FMT_HALF: begin
                sel_o[LN_HALF] = half_en_i;
                legal_o        = half_en_i;
            end
            FMT_RSVD: begin
                sel_o   = '0;
                legal_o = 1'b0;
            end
            default: begin
                sel_o   = '0;
                legal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 64
) (
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    output logic                 nan_o,
    output logic [OUT_W-1:0]     key_a_o,
    output logic [OUT_W-1:0]     key_b_o
);

    localparam int W = 1 + EXP_W + MAN_W;

    function automatic logic is_nan(input logic [W-1:0] x);
        return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
    endfunction

    // Zeros fold to one key; negatives are inverted so the unsigned order follows the value
    function automatic logic [W-1:0] order_key(input logic [W-1:0] x);
        logic [W-2:0] mag;
        logic         neg;
        mag = x[W-2:0];
        neg = x[W-1] && (mag != '0);
        return neg ? {1'b0, ~mag} : {1'b1, mag};
    endfunction

    logic [W-1:0] ka, kb;

    always_comb begin
        ka      = order_key(a_i);
        kb      = order_key(b_i);
        nan_o   = is_nan(a_i) || is_nan(b_i);
        key_a_o = OUT_W'(ka);
        key_b_o = OUT_W'(kb);
    end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int KEY_W = 64
) (
    input  logic [KEY_W-1:0] key_a_i,
    input  logic [KEY_W-1:0] key_b_i,
    input  logic             unord_i,
    output logic [3:0]       cc_o
);

    always_comb begin
        if (unord_i)                 cc_o = CC_UNORD;
        else if (key_a_i < key_b_i)  cc_o = CC_LT;
        else if (key_a_i == key_b_i) cc_o = CC_EQ;
        else                         cc_o = CC_GT;
    end

endmodule

// File: rtl/fp_sigcmp.sv
module fp_sigcmp
    import fpcmp_pkg::*;
#(
    parameter int H_EXP = 5,
    parameter int H_MAN = 10,
    parameter int S_EXP = 8,
    parameter int S_MAN = 23,
    parameter int D_EXP = 11,
    parameter int D_MAN = 52
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  fmt,
    input  logic        zero_sel,
    input  logic        half_en,
    input  logic        trap_en,
    input  logic        clr_inv,
    input  logic [63:0] opa,
    input  logic [63:0] opb,
    output logic        out_valid,
    output logic [3:0]  flags,
    output logic        undef,
    output logic        inv_sticky,
    output logic        trap_pulse
);

    localparam int DW = 1 + D_EXP + D_MAN;

    logic                 legal;
    logic [NUM_LANES-1:0] sel;
    logic [63:0]          opb_eff;
    logic [NUM_LANES-1:0] lane_nan;
    logic [DW-1:0]        lane_ka [NUM_LANES];
    logic [DW-1:0]        lane_kb [NUM_LANES];
    logic [DW-1:0]        key_a, key_b;
    logic                 unord;
    logic [3:0]           cc_new;
    cmp_state_t           st_d, st_q;

    fpcmp_decode u_dec (
        .fmt_i     (fmt),
        .half_en_i (half_en),
        .legal_o   (legal),
        .sel_o     (sel)
    );

    assign opb_eff = zero_sel ? 64'd0 : opb;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int EW = (g == LN_HALF) ? H_EXP : (g == LN_SINGLE) ? S_EXP : D_EXP;
        localparam int MW = (g == LN_HALF) ? H_MAN : (g == LN_SINGLE) ? S_MAN : D_MAN;
        localparam int LW = 1 + EW + MW;
        fpcmp_lane #(.EXP_W(EW), .MAN_W(MW), .OUT_W(DW)) u_lane (
            .a_i     (opa[LW-1:0]),
            .b_i     (opb_eff[LW-1:0]),
            .nan_o   (lane_nan[g]),
            .key_a_o (lane_ka[g]),
            .key_b_o (lane_kb[g])
        );
    end

    always_comb begin
        key_a = '0;
        key_b = '0;
        unord = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (sel[i]) begin
                key_a = key_a | lane_ka[i];
                key_b = key_b | lane_kb[i];
                unord = unord | lane_nan[i];
            end
        end
    end

    fpcmp_order #(.KEY_W(DW)) u_ord (
        .key_a_i (key_a),
        .key_b_i (key_b),
        .unord_i (unord),
        .cc_o    (cc_new)
    );

    always_comb begin
        logic inv_evt;
        st_d       = st_q;
        inv_evt    = in_valid && legal && unord;
        st_d.vld   = in_valid;
        st_d.undef = in_valid && !legal;
        if (in_valid && legal) st_d.cc = cc_new;
        st_d.sticky = (st_q.sticky && !clr_inv) || (inv_evt && !trap_en);
        st_d.trap   = inv_evt && trap_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign flags      = st_q.cc;
    assign undef      = st_q.undef;
    assign inv_sticky = st_q.sticky;
    assign trap_pulse = st_q.trap;

    p_vld_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_stray_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_undef_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal) |=> (undef && $stable(flags) && !trap_pulse));
    p_cc_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !undef) |-> (flags == CC_LT || flags == CC_EQ ||
                                   flags == CC_GT || flags == CC_UNORD));
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_sticky && !clr_inv) |=> inv_sticky);
    p_trap_no_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && trap_en && !clr_inv) |=> $stable(inv_sticky));
    p_trap_needs_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> out_valid);

endmodule

// File: tb/sim_fp_sigcmp.sv
module sim_fp_sigcmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        zero_sel = 1'b0;
    logic        half_en = 1'b1;
    logic        trap_en = 1'b0;
    logic        clr_inv = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [3:0]  flags;
    logic        undef;
    logic        inv_sticky;
    logic        trap_pulse;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fp_sigcmp u0 (.*);

    // {fmt, zero_sel, half_en, a, b, expected cc, expected invalid}
    localparam int NV = 23;
    localparam logic [136:0] TBL [NV] = '{
        {2'b00,1'b0,1'b1,64'h3F800000,64'h40000000,4'b1000,1'b0},
        {2'b00,1'b0,1'b1,64'h40000000,64'h3F800000,4'b0010,1'b0},
        {2'b00,1'b0,1'b1,64'hC0000000,64'h3F800000,4'b1000,1'b0},
        {2'b00,1'b0,1'b1,64'h3F800000,64'h3F800000,4'b0110,1'b0},
        {2'b00,1'b0,1'b1,64'h00000000,64'h80000000,4'b0110,1'b0},
        {2'b00,1'b0,1'b1,64'h00000001,64'h80000001,4'b0010,1'b0},
        {2'b00,1'b0,1'b1,64'h00000001,64'h00000002,4'b1000,1'b0},
        {2'b00,1'b0,1'b1,64'h7F800000,64'h7F7FFFFF,4'b0010,1'b0},
        {2'b00,1'b0,1'b1,64'h7FC00000,64'h3F800000,4'b0011,1'b1},
        {2'b00,1'b0,1'b1,64'h3F800000,64'h7F800001,4'b0011,1'b1},
        {2'b01,1'b0,1'b1,64'hBFF0000000000000,64'h3FF0000000000000,4'b1000,1'b0},
        {2'b01,1'b0,1'b1,64'h7FEFFFFFFFFFFFFF,64'h7FF0000000000000,4'b1000,1'b0},
        {2'b01,1'b0,1'b1,64'hFFF0000000000000,64'hFFEFFFFFFFFFFFFF,4'b1000,1'b0},
        {2'b01,1'b0,1'b1,64'h7FF0000000000001,64'h7FF0000000000001,4'b0011,1'b1},
        {2'b01,1'b1,1'b1,64'h8000000000000000,64'h3FF0000000000000,4'b0110,1'b0},
        {2'b01,1'b1,1'b1,64'hBFF0000000000000,64'h7FF8000000000000,4'b1000,1'b0},
        {2'b11,1'b0,1'b1,64'h3C00,64'hBC00,4'b0010,1'b0},
        {2'b11,1'b0,1'b1,64'h8000,64'h0000,4'b0110,1'b0},
        {2'b11,1'b0,1'b1,64'h0001,64'h0002,4'b1000,1'b0},
        {2'b11,1'b0,1'b1,64'h7E00,64'h3C00,4'b0011,1'b1},
        {2'b11,1'b1,1'b1,64'hFC00,64'h7C01,4'b1000,1'b0},
        {2'b00,1'b0,1'b1,64'hFFFFFFFF3F800000,64'h0000000040000000,4'b1000,1'b0},
        {2'b11,1'b0,1'b1,64'hFFFFFFFFFFFF3C00,64'h7FF8000000003C00,4'b0110,1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // drive one request at a falling edge; outputs are sampled at the next falling edge
    task automatic issue(input logic [1:0] f, input logic z, input logic he,
                         input logic te, input logic clr,
                         input logic [63:0] a, input logic [63:0] b);
        fmt = f; zero_sel = z; half_en = he; trap_en = te; clr_inv = clr;
        opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; clr_inv = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset", {out_valid, flags, undef, inv_sticky, trap_pulse}, 8'h00);

        // table walk: each vector clears the sticky bit in the same cycle (set must win, R8)
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i][136:135], TBL[i][134], TBL[i][133], 1'b0, 1'b1,
                  TBL[i][132:69], TBL[i][68:5]);
            chk($sformatf("R1 R4 R5 R6 R7 vec%0d cc", i), {3'b0, out_valid, flags},
                {3'b0, 1'b1, TBL[i][4:1]});
            chk($sformatf("R6 R8 vec%0d inv", i), {6'b0, inv_sticky, undef},
                {6'b0, TBL[i][0], 1'b0});
        end

        // R10: no request, no valid
        @(negedge clk);
        chk("R10 idle", {7'b0, out_valid}, 8'h00);

        // leave cc = GT, then the reserved code must hold it (R2)
        issue(2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 64'h40000000, 64'h3F800000);
        issue(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 64'h7FF8000000000000, 64'h7FF8000000000000);
        chk("R2 reserved", {out_valid, flags, undef, inv_sticky, trap_pulse},
            {1'b1, 4'b0010, 1'b1, 1'b0, 1'b0});

        // R3: half without the enable
        issue(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 64'h7E00, 64'h3C00);
        chk("R3 half disabled", {out_valid, flags, undef, inv_sticky, trap_pulse},
            {1'b1, 4'b0010, 1'b1, 1'b0, 1'b0});
        issue(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 64'h3C00, 64'h3C00);
        chk("R3 half enabled", {3'b0, flags, undef}, {3'b0, 4'b0110, 1'b0});

        // R8: sticky holds across idle cycles, then clears
        issue(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 64'h7F800001, 64'h0);
        repeat (3) @(negedge clk);
        chk("R8 sticky held", {7'b0, inv_sticky}, 8'h01);
        issue(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 64'h3F800000, 64'h3F800000);
        chk("R8 sticky held by clean op", {7'b0, inv_sticky}, 8'h01);
        clr_inv = 1'b1;
        @(negedge clk);
        clr_inv = 1'b0;
        chk("R8 sticky cleared", {7'b0, inv_sticky}, 8'h00);

        // R9: trap mode
        issue(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 64'h7FF8000000000000, 64'h0);
        chk("R9 trap pulse", {4'b0, flags[1:0], inv_sticky, trap_pulse}, {4'b0, 2'b11, 1'b0, 1'b1});
        @(negedge clk);
        chk("R9 trap one cycle", {6'b0, inv_sticky, trap_pulse}, 8'h00);
        issue(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 64'h3FF0000000000000, 64'h0);
        chk("R9 no trap clean", {7'b0, trap_pulse}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule